// File: doc/BRIEF.md
# Meta-Instruction Priority Queue

This block gathers configuration commands raised by the cores of a many-core processor and hands them, one at a time, to a single control engine. Each core owns a private submit lane. A core raises a one-cycle valid strobe with a 3-bit priority and a command word. There is no authorization or ready signal. The queue stores the command in a slot reserved for that core and raises the core's suspend line. That line stays high until the control engine reports the command as finished.

The control engine always sees the most urgent pending command at the head outputs. A pulse on `out_take` removes that command from the pending set. The core stays suspended while its command executes. A later `done_valid` pulse, naming the core, releases the core and frees its slot.

Among commands of equal priority, the one accepted first leaves first. A core that submits while it already holds a live command is refused, and the refusal sets a sticky error bit for that core.

Top module: `meta_prio_queue`

## Requirements
- R1: After reset, `meta` and `err` are all zero and `out_valid` is low.
- R2: A submission from a core whose `meta` bit is low is accepted. From the next cycle the core's `meta` bit is high and the entry can be selected, with its priority and word unchanged.
- R3: The head outputs show the pending entry with the numerically largest priority, where 7 is the most urgent and 0 the least. Fragment-termination commands are expected to use larger values than fragment-creation commands.
- R4: Among pending entries of equal priority that were accepted in different cycles, the one accepted earlier is presented first.
- R5: Among entries of equal priority that were accepted in the same cycle, the lower core index is presented first.
- R6: A submission from a core whose `meta` bit is high is rejected. This includes a submission made in the same cycle as that core's completion. The stored entry stays as it was, and the core's `err` bit goes high on the next cycle and stays high until reset.
- R7: `out_take` while `out_valid` is high removes the head entry from the pending set from the next cycle. The owning core's `meta` bit stays high.
- R8: `done_valid` with `done_core` = k clears `meta[k]` on the next cycle and discards core k's entry, whether or not that entry was taken. Core k may then submit again.
- R9: `out_take` while `out_valid` is low has no effect. `done_valid` naming a core whose `meta` bit is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sub_valid | input | NCORES | Per-core submit strobe |
| sub_prio | input | NCORES*PRIO_W | Per-core priority; core i uses bits [i*PRIO_W +: PRIO_W] |
| sub_word | input | NCORES*WORD_W | Per-core command word; core i uses bits [i*WORD_W +: WORD_W] |
| out_take | input | 1 | Consumer removes the head entry |
| done_valid | input | 1 | Completion strobe |
| done_core | input | ID_W | Core whose command has completed |
| out_valid | output | 1 | At least one entry is pending |
| out_core | output | ID_W | Core that owns the head entry |
| out_prio | output | PRIO_W | Priority of the head entry |
| out_word | output | WORD_W | Command word of the head entry |
| meta | output | NCORES | Per-core suspend indication |
| err | output | NCORES | Per-core sticky duplicate-submission flag |

## Verification
A corrupted age relation between two slots shows up on the first cycle in which both slots are pending at equal priority: the head names the wrong core, and the scoreboard sees the wrong core and word at the following take. A pending bit left behind by a take or a completion keeps `out_valid` high, or brings the same entry back, immediately after. A suspend bit that is wrongly kept or wrongly cleared shows at `meta` one cycle after the submission or completion that should have changed it. Because the bench compares every taken entry against an ordered list of expected entries, any selection fault appears at the very next take.

// File: rtl/meta_prio_queue.sv
module meta_prio_queue #(
  parameter int NCORES = 4,
  parameter int PRIO_W = 3,
  parameter int WORD_W = 16,
  localparam int ID_W = (NCORES > 1) ? $clog2(NCORES) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NCORES-1:0]        sub_valid,
  input  logic [NCORES*PRIO_W-1:0] sub_prio,
  input  logic [NCORES*WORD_W-1:0] sub_word,
  input  logic                     out_take,
  input  logic                     done_valid,
  input  logic [ID_W-1:0]          done_core,
  output logic                     out_valid,
  output logic [ID_W-1:0]          out_core,
  output logic [PRIO_W-1:0]        out_prio,
  output logic [WORD_W-1:0]        out_word,
  output logic [NCORES-1:0]        meta,
  output logic [NCORES-1:0]        err
);

  logic [NCORES-1:0] act, pend, win, accept, take_vec, done_vec;
  logic [PRIO_W-1:0] prio_q [NCORES];
  logic [WORD_W-1:0] word_q [NCORES];
  logic [NCORES-1:0] older  [NCORES];
  logic [ID_W-1:0]   win_idx;

  assign accept   = sub_valid & ~act;
  assign take_vec = (out_valid && out_take) ? win : '0;
  assign meta     = act;
  assign out_valid = |pend;
  assign out_core  = win_idx;
  assign out_prio  = prio_q[win_idx];
  assign out_word  = word_q[win_idx];

  always_comb begin
    done_vec = '0;
    for (int i = 0; i < NCORES; i++)
      if (done_valid && done_core == ID_W'(i)) done_vec[i] = 1'b1;
  end

  always_comb begin
    for (int i = 0; i < NCORES; i++) begin
      win[i] = pend[i];
      for (int j = 0; j < NCORES; j++)
        if (j != i && pend[j] &&
            !(prio_q[i] > prio_q[j] || (prio_q[i] == prio_q[j] && older[i][j])))
          win[i] = 1'b0;
    end
  end

  always_comb begin
    win_idx = '0;
    for (int i = 0; i < NCORES; i++)
      if (win[i]) win_idx = ID_W'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act  <= '0;
      pend <= '0;
      err  <= '0;
      for (int i = 0; i < NCORES; i++) begin
        prio_q[i] <= '0;
        word_q[i] <= '0;
        older[i]  <= '0;
      end
    end else begin
      act  <= (act & ~done_vec) | accept;
      pend <= (pend & ~take_vec & ~done_vec) | accept;
      err  <= err | (sub_valid & act);
      for (int i = 0; i < NCORES; i++) begin
        if (accept[i]) begin
          prio_q[i] <= sub_prio[i*PRIO_W +: PRIO_W];
          word_q[i] <= sub_word[i*WORD_W +: WORD_W];
        end
        for (int j = 0; j < NCORES; j++) begin
          if (i == j)                       older[i][j] <= 1'b0;
          else if (accept[i] && accept[j])  older[i][j] <= (i < j);
          else if (accept[i])               older[i][j] <= 1'b0;
          else if (accept[j])               older[i][j] <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/meta_prio_queue_chk.sv
module meta_prio_queue_chk #(
  parameter int NCORES = 4,
  parameter int ID_W   = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NCORES-1:0] sub_valid,
  input logic              out_take,
  input logic              done_valid,
  input logic [ID_W-1:0]   done_core,
  input logic              out_valid,
  input logic [ID_W-1:0]   out_core,
  input logic [NCORES-1:0] meta,
  input logic [NCORES-1:0] err
);

  AST_HEAD_OWNER_SUSPENDED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> meta[out_core]);                                                // R7

  AST_SUBMIT_SUSPENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (|(sub_valid & ~meta)) |=> ((meta & $past(sub_valid & ~meta)) == $past(sub_valid & ~meta))); // R2

  AST_DUPLICATE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (|(sub_valid & meta)) |=> ((err & $past(sub_valid & meta)) == $past(sub_valid & meta)));     // R6

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (|err) |=> ((err & $past(err)) == $past(err)));                                // R6

  AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && !sub_valid[done_core]) |=> !meta[$past(done_core)]);            // R8

  AST_QUIET_HEAD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_take && !done_valid && !(|sub_valid)) |=> (out_valid && $stable(out_core))); // R3

endmodule

bind meta_prio_queue meta_prio_queue_chk #(.NCORES(NCORES), .ID_W(ID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sub_valid(sub_valid), .out_take(out_take),
  .done_valid(done_valid), .done_core(done_core), .out_valid(out_valid),
  .out_core(out_core), .meta(meta), .err(err)
);

// File: tb/test_meta_prio_queue.sv
module test_meta_prio_queue;
  localparam int NC = 4, PW = 3, WW = 16, IW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NC-1:0] sub_valid = '0;
  logic [NC*PW-1:0] sub_prio = '0;
  logic [NC*WW-1:0] sub_word = '0;
  logic out_take = 1'b0, done_valid = 1'b0;
  logic [IW-1:0] done_core = '0;
  logic out_valid;
  logic [IW-1:0] out_core;
  logic [PW-1:0] out_prio;
  logic [WW-1:0] out_word;
  logic [NC-1:0] meta, err;

  int nchk = 0, nfail = 0;

  typedef struct { int core; logic [WW-1:0] word; string req; } item_t;
  item_t exp_q[$];

  always #4 clk = ~clk;

  meta_prio_queue #(.NCORES(NC), .PRIO_W(PW), .WORD_W(WW)) i_meta_prio_queue (
    .clk(clk), .rst_n(rst_n), .sub_valid(sub_valid), .sub_prio(sub_prio),
    .sub_word(sub_word), .out_take(out_take), .done_valid(done_valid),
    .done_core(done_core), .out_valid(out_valid), .out_core(out_core),
    .out_prio(out_prio), .out_word(out_word), .meta(meta), .err(err));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic set_sub(int c, int p, logic [WW-1:0] w);
    sub_valid[c] = 1'b1;
    sub_prio[c*PW +: PW] = PW'(p);
    sub_word[c*WW +: WW] = w;
  endtask

  task automatic push_exp(int c, logic [WW-1:0] w, string req);
    item_t it;
    it.core = c; it.word = w; it.req = req;
    exp_q.push_back(it);
  endtask

  task automatic submit_go();
    tick(); sub_valid = '0;
  endtask

  task automatic take_one();
    out_take = 1'b1; tick(); out_take = 1'b0;
  endtask

  task automatic finish_core(int c);
    done_valid = 1'b1; done_core = IW'(c); tick(); done_valid = 1'b0;
  endtask

  // monitor: pops the scoreboard on every effective take
  always @(negedge clk) begin
    if (rst_n && out_take && out_valid) begin
      if (exp_q.size() == 0) begin
        nchk++; nfail++;
        $display("FAIL R3: actual take of core %0d expected no entry", out_core);
      end else begin
        item_t it;
        it = exp_q.pop_front();
        check({it.req, " core"}, 32'(out_core), 32'(it.core));
        check({it.req, " word"}, 32'(out_word), 32'(it.word));
      end
    end
  end

  initial begin
    #(200000 * 8);
    nchk++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    tick(); tick();
    check("R1 meta", 32'(meta), 0);
    check("R1 err", 32'(err), 0);
    check("R1 out_valid", 32'(out_valid), 0);
    rst_n = 1'b1; tick();

    // R2 / R3: two priorities, same cycle
    set_sub(1, 2, 16'hA101); set_sub(3, 5, 16'hA303); submit_go();
    check("R2 meta", 32'(meta), 32'b1010);
    check("R3 head core", 32'(out_core), 3);
    check("R3 head prio", 32'(out_prio), 5);
    push_exp(3, 16'hA303, "R3"); push_exp(1, 16'hA101, "R3");
    take_one();
    check("R7 meta after take", 32'(meta), 32'b1010);
    check("R7 next head", 32'(out_core), 1);
    take_one();
    check("R7 empty after takes", 32'(out_valid), 0);
    finish_core(3); finish_core(1);
    check("R8 meta released", 32'(meta), 0);

    // R4: equal priority, different cycles
    set_sub(2, 4, 16'hB202); submit_go();
    set_sub(0, 4, 16'hB000); submit_go();
    push_exp(2, 16'hB202, "R4"); push_exp(0, 16'hB000, "R4");
    take_one(); take_one();
    finish_core(2); finish_core(0);

    // R5: equal priority, same cycle, plus a lower one
    set_sub(3, 6, 16'hC303); set_sub(1, 6, 16'hC101); set_sub(2, 1, 16'hC202); submit_go();
    push_exp(1, 16'hC101, "R5"); push_exp(3, 16'hC303, "R5"); push_exp(2, 16'hC202, "R3");
    take_one(); take_one(); take_one();
    finish_core(1); finish_core(3); finish_core(2);

    // R6: duplicate submission
    set_sub(0, 3, 16'hD000); submit_go();
    set_sub(0, 7, 16'hDEAD); submit_go();
    check("R6 err set", 32'(err), 32'b0001);
    check("R6 prio kept", 32'(out_prio), 3);
    check("R6 word kept", 32'(out_word), 32'hD000);
    set_sub(0, 5, 16'hDBAD); done_valid = 1'b1; done_core = 2'd0; tick();
    sub_valid = '0; done_valid = 1'b0;
    check("R6 same-cycle resubmit rejected", 32'(meta), 0);
    check("R6 err sticky", 32'(err), 32'b0001);

    // R9: ineffective take and completion
    take_one();
    check("R9 empty take", 32'(out_valid), 0);
    set_sub(2, 0, 16'hE202); submit_go();
    finish_core(1);
    check("R9 idle done meta", 32'(meta), 32'b0100);
    check("R9 idle done head", 32'(out_word), 32'hE202);
    push_exp(2, 16'hE202, "R9");
    take_one();
    check("R7 suspended while executing", 32'(meta), 32'b0100);
    finish_core(2);
    check("R8 release", 32'(meta), 0);

    // R8: resubmit, then complete while still pending
    set_sub(2, 1, 16'hF202); submit_go();
    check("R8 resubmit meta", 32'(meta), 32'b0100);
    check("R8 resubmit word", 32'(out_word), 32'hF202);
    finish_core(2);
    check("R8 pending discarded", 32'(out_valid), 0);
    check("R8 pending released", 32'(meta), 0);

    tick();
    check("R3 scoreboard drained", 32'(exp_q.size()), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule